// File: doc/BRIEF.md
# Wishbone to Character-LCD Bridge

This block is a Wishbone slave that turns single-byte host bus cycles into timed transfers on the parallel bus of a character LCD. The host selects between the panel's instruction register and data register with one address bit. It selects a write or a read with the write-enable line. On the panel side the block drives a register-select line and a read/write line, which together form a 2-bit address bus. It also drives an enable strobe and an 8-bit data bus. The data bus is split into an output byte, an input byte and an output-enable; a pad ring joins the three into one tri-state bus.

When a bus cycle is seen, an internal sequencer runs three counted phases, each a parameter in clock cycles. First comes address setup with the enable low. Then the enable pulse. Then hold with the enable low again. Only after these does the block raise the acknowledge. On a read, the panel byte is captured in the last cycle of the enable pulse and presented to the host. The acknowledge stays high until the master releases its strobe, so one long strobe cannot start a second panel transfer.

Top module: `lcd_wb_bridge`

## Requirements
- R1: After reset, ack_o, pnl_en_o and pnl_dq_oe_o are low, pnl_addr_o[1] is high (read direction) and dat_o is 0.
- R2: pnl_addr_o[0] (register select, 1 = data register, 0 = instruction register) takes the value of adr_i one cycle after it is sampled while idle. It keeps the value sampled at the start edge for the whole transfer.
- R3: A write (we_i = 1) drives pnl_addr_o[1] low, raises pnl_dq_oe_o and puts the dat_i byte on pnl_dq_o. These hold from the cycle after the start edge until the acknowledge.
- R4: A read (we_i = 0) keeps pnl_addr_o[1] high and pnl_dq_oe_o low throughout. It presents on dat_o the byte that pnl_dq_i carried in the last cycle of the enable pulse.
- R5: After the start edge (the first rising edge with stb_i and cyc_i both high), pnl_en_o stays low for SETUP_CYC cycles, then is high for PULSE_CYC cycles, then low for HOLD_CYC cycles. After these, ack_o rises. Defaults are 2, 12 and 2.
- R6: pnl_en_o is never high together with ack_o. ack_o falls on the first rising edge that sees stb_i or cyc_i low.
- R7: While the master keeps stb_i and cyc_i high after the acknowledge, ack_o stays high and no new enable pulse is produced.
- R8: The dat_o value of a read is stable while ack_o is high and remains until the next read capture.
- R9: stb_i high with cyc_i low starts no transfer: pnl_en_o and ack_o stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, all activity on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| adr_i | input | 1 | Register select from the host |
| dat_i | input | 8 | Write byte from the host |
| dat_o | output | 8 | Read byte to the host |
| we_i | input | 1 | 1 = write, 0 = read |
| stb_i | input | 1 | Bus strobe |
| cyc_i | input | 1 | Bus cycle valid |
| ack_o | output | 1 | Transfer acknowledge |
| pnl_addr_o | output | 2 | Panel bit 0 register select, bit 1 read/write (1 = read) |
| pnl_en_o | output | 1 | Panel enable strobe |
| pnl_dq_o | output | 8 | Byte driven toward the panel |
| pnl_dq_i | input | 8 | Byte returned by the panel |
| pnl_dq_oe_o | output | 1 | Output-enable for the panel data bus |

## Verification
Directed writes and reads to both register-select values establish the phase lengths and line levels. A long-strobe case tells an acknowledge that waits for release apart from one that restarts. A strobe without cycle-valid checks that it is ignored. During the enable pulse the bench model drives random bytes on the panel bus and the true byte only in the last cycle, so a capture in any other cycle is caught. Seeded random mixes of direction, address, data and release delay then confirm that write data, read data and register select never leak between transfers.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_PULSE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_ACK   = 3'd4
   } lcdb_state_e;

   function automatic int lcdb_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int lcdb_bits(input int v);
      int n;
      n = 1;
      while ((1 << n) <= v) n++;
      return n;
   endfunction

endpackage

// File: rtl/lcdb_timer.sv
module lcdb_timer #(
   parameter int CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_TIMER_DECR: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && cnt_q != '0) |=> !zero_o || ($past(cnt_q) == CW'(1))); // R5

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
   import lcdb_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 12,
   parameter int HOLD_CYC  = 2,
   parameter int CW        = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          stb_i,
   input  logic          cyc_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [CW-1:0] tmr_val_o,
   output logic          start_o,
   output logic          capture_o,
   output logic          drive_end_o,
   output logic          idle_o,
   output logic          busy_o,
   output logic          en_o,
   output logic          ack_o
);

   localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

   lcdb_state_e state_q;
   logic        req;
   logic        setup_done, pulse_done, hold_done;

   assign req        = stb_i && cyc_i;
   assign setup_done = (state_q == ST_SETUP) && tmr_zero_i;
   assign pulse_done = (state_q == ST_PULSE) && tmr_zero_i;
   assign hold_done  = (state_q == ST_HOLD)  && tmr_zero_i;

   assign idle_o      = (state_q == ST_IDLE);
   assign busy_o      = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
   assign start_o     = idle_o && req;
   assign capture_o   = pulse_done;
   assign drive_end_o = hold_done;

   always_comb begin
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      if (start_o) begin
         tmr_load_o = 1'b1;
         tmr_val_o  = SETUP_LD;
      end else if (setup_done) begin
         tmr_load_o = 1'b1;
         tmr_val_o  = PULSE_LD;
      end else if (pulse_done) begin
         tmr_load_o = 1'b1;
         tmr_val_o  = HOLD_LD;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         en_o    <= 1'b0;
         ack_o   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req) state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               if (tmr_zero_i) begin
                  state_q <= ST_PULSE;
                  en_o    <= 1'b1;
               end
            end
            ST_PULSE: begin
               if (tmr_zero_i) begin
                  state_q <= ST_HOLD;
                  en_o    <= 1'b0;
               end
            end
            ST_HOLD: begin
               if (tmr_zero_i) begin
                  state_q <= ST_ACK;
                  ack_o   <= 1'b1;
               end
            end
            ST_ACK: begin
               if (!req) begin
                  state_q <= ST_IDLE;
                  ack_o   <= 1'b0;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               en_o    <= 1'b0;
               ack_o   <= 1'b0;
            end
         endcase
      end
   end

   AST_EN_ACK_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
      !(en_o && ack_o)); // R6
   AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && !(stb_i && cyc_i)) |=> !ack_o); // R6
   AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && stb_i && cyc_i) |=> (ack_o && !en_o)); // R7
   AST_EN_LOW_BEFORE_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(ack_o) |-> $past(!en_o)); // R5
   AST_NO_START_WITHOUT_CYC: assert property (@(posedge clk_i) disable iff (rst_i)
      (idle_o && !cyc_i) |=> !en_o && !ack_o); // R9

endmodule

// File: rtl/lcdb_datapath.sv
module lcdb_datapath #(
   parameter int DW            = 8,
   parameter bit RS_TRACK_IDLE = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          idle_i,
   input  logic          busy_i,
   input  logic          start_i,
   input  logic          capture_i,
   input  logic          drive_end_i,
   input  logic          adr_i,
   input  logic          we_i,
   input  logic [DW-1:0] dat_i,
   input  logic [DW-1:0] pnl_dq_i,
   output logic          rs_o,
   output logic          rw_o,
   output logic          oe_o,
   output logic [DW-1:0] wdata_o,
   output logic [DW-1:0] rdata_o
);

   logic rs_q;

   generate
      if (RS_TRACK_IDLE) begin : g_rs_track
         always_ff @(posedge clk_i) begin
            if (rst_i)       rs_q <= 1'b0;
            else if (idle_i) rs_q <= adr_i;
         end
      end else begin : g_rs_latch
         always_ff @(posedge clk_i) begin
            if (rst_i)        rs_q <= 1'b0;
            else if (start_i) rs_q <= adr_i;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rw_o    <= 1'b1;
         oe_o    <= 1'b0;
         wdata_o <= '0;
         rdata_o <= '0;
      end else begin
         if (start_i) begin
            rw_o    <= !we_i;
            oe_o    <= we_i;
            wdata_o <= dat_i;
         end else if (drive_end_i) begin
            oe_o    <= 1'b0;
         end
         if (capture_i && rw_o) begin
            rdata_o <= pnl_dq_i;
         end
      end
   end

   assign rs_o = rs_q;

   AST_OE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
      oe_o |-> !rw_o); // R3
   AST_RS_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_i && $past(busy_i)) |-> $stable(rs_q)); // R2
   AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(capture_i) |-> $stable(rdata_o)); // R8

endmodule

// File: rtl/lcd_wb_bridge.sv
module lcd_wb_bridge
   import lcdb_pkg::*;
#(
   parameter int SETUP_CYC     = 2,
   parameter int PULSE_CYC     = 12,
   parameter int HOLD_CYC      = 2,
   parameter int DW            = 8,
   parameter bit RS_TRACK_IDLE = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          adr_i,
   input  logic [DW-1:0] dat_i,
   output logic [DW-1:0] dat_o,
   input  logic          we_i,
   input  logic          stb_i,
   input  logic          cyc_i,
   output logic          ack_o,
   output logic [1:0]    pnl_addr_o,
   output logic          pnl_en_o,
   output logic [DW-1:0] pnl_dq_o,
   input  logic [DW-1:0] pnl_dq_i,
   output logic          pnl_dq_oe_o
);

   localparam int MAX_CYC = lcdb_max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
   localparam int CW      = lcdb_bits(MAX_CYC);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("SETUP_CYC must be at least 1");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
   endgenerate

   logic          tmr_load, tmr_zero;
   logic [CW-1:0] tmr_val;
   logic          start, capture, drive_end, idle, busy;
   logic          rs, rw;

   lcdb_timer #(.CW(CW)) i_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   lcdb_seq #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .CW        (CW)
   ) i_seq (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .stb_i       (stb_i),
      .cyc_i       (cyc_i),
      .tmr_zero_i  (tmr_zero),
      .tmr_load_o  (tmr_load),
      .tmr_val_o   (tmr_val),
      .start_o     (start),
      .capture_o   (capture),
      .drive_end_o (drive_end),
      .idle_o      (idle),
      .busy_o      (busy),
      .en_o        (pnl_en_o),
      .ack_o       (ack_o)
   );

   lcdb_datapath #(
      .DW            (DW),
      .RS_TRACK_IDLE (RS_TRACK_IDLE)
   ) i_dp (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .idle_i      (idle),
      .busy_i      (busy),
      .start_i     (start),
      .capture_i   (capture),
      .drive_end_i (drive_end),
      .adr_i       (adr_i),
      .we_i        (we_i),
      .dat_i       (dat_i),
      .pnl_dq_i    (pnl_dq_i),
      .rs_o        (rs),
      .rw_o        (rw),
      .oe_o        (pnl_dq_oe_o),
      .wdata_o     (pnl_dq_o),
      .rdata_o     (dat_o)
   );

   assign pnl_addr_o = {rw, rs};

   AST_DOUT_STABLE_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
      (ack_o && $past(ack_o)) |-> $stable(dat_o)); // R8
   AST_OE_OFF_AT_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
      ack_o |-> !pnl_dq_oe_o); // R3
   AST_ADDR_STABLE_EN: assert property (@(posedge clk_i) disable iff (rst_i)
      pnl_en_o |-> $stable(pnl_addr_o)); // R2

endmodule

// File: tb/test_lcd_wb_bridge.sv
module test_lcd_wb_bridge;

   localparam int S = 2;
   localparam int P = 12;
   localparam int H = 2;

   logic       clk = 1'b0;
   logic       rst;
   logic       adr_i, we_i, stb_i, cyc_i;
   logic [7:0] dat_i, pnl_dq_i;
   logic [7:0] dat_o, pnl_dq_o;
   logic       ack_o, pnl_en_o, pnl_dq_oe_o;
   logic [1:0] pnl_addr_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   lcd_wb_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) i_lcd_wb_bridge (
      .clk_i(clk), .rst_i(rst), .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o),
      .we_i(we_i), .stb_i(stb_i), .cyc_i(cyc_i), .ack_o(ack_o),
      .pnl_addr_o(pnl_addr_o), .pnl_en_o(pnl_en_o), .pnl_dq_o(pnl_dq_o),
      .pnl_dq_i(pnl_dq_i), .pnl_dq_oe_o(pnl_dq_oe_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_rw(input bit we);
      return !we;
   endfunction

   task automatic xfer(input bit we, input bit adr, input logic [7:0] wd,
                       input logic [7:0] pv, input int keep);
      int s = 0, p = 0, h = 0, guard = 0;
      bit ok_rw = 1, ok_oe = 1, ok_dq = 1, ok_rs = 1;
      logic [7:0] held;
      @(negedge clk);
      adr_i = adr; we_i = we; dat_i = wd; stb_i = 1'b1; cyc_i = 1'b1;
      forever begin
         @(negedge clk);
         guard++;
         if (ack_o || guard > 100) break;
         if (pnl_en_o) p++;
         else if (p == 0) s++;
         else h++;
         if (pnl_addr_o[1] !== exp_rw(we)) ok_rw = 0;
         if (pnl_dq_oe_o !== we) ok_oe = 0;
         if (we && pnl_dq_o !== wd) ok_dq = 0;
         if (pnl_addr_o[0] !== adr) ok_rs = 0;
         pnl_dq_i = (pnl_en_o && p == P) ? pv : 8'($urandom);
      end
      chk(guard <= 100, "R5 ack timeout", guard, S + P + H + 1);
      chk(s == S, "R5 setup cycles", s, S);
      chk(p == P, "R5 pulse cycles", p, P);
      chk(h == H, "R5 hold cycles", h, H);
      chk(ok_rs, "R2 register select", ok_rs, 1);
      chk(pnl_en_o == 1'b0, "R6 enable low at ack", pnl_en_o, 0);
      if (we) begin
         chk(ok_rw, "R3 rw low on write", ok_rw, 1);
         chk(ok_oe, "R3 oe high on write", ok_oe, 1);
         chk(ok_dq, "R3 write byte on bus", ok_dq, 1);
      end else begin
         chk(ok_rw, "R4 rw high on read", ok_rw, 1);
         chk(ok_oe, "R4 oe low on read", ok_oe, 1);
         chk(dat_o == pv, "R4 read byte", dat_o, pv);
      end
      held = dat_o;
      for (int k = 0; k < keep; k++) begin
         @(negedge clk);
         chk(ack_o == 1'b1, "R7 ack held", ack_o, 1);
         chk(pnl_en_o == 1'b0, "R7 no new pulse", pnl_en_o, 0);
         chk(dat_o == held, "R8 dat_o stable in ack", dat_o, held);
      end
      stb_i = 1'b0; cyc_i = 1'b0;
      @(negedge clk);
      chk(ack_o == 1'b0, "R6 ack released", ack_o, 0);
      chk(dat_o == held, "R8 dat_o kept", dat_o, held);
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] last_rd;
      void'($urandom(32'd1234));
      rst = 1'b1; adr_i = 0; we_i = 0; stb_i = 0; cyc_i = 0; dat_i = 0; pnl_dq_i = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(ack_o == 0, "R1 ack", ack_o, 0);
      chk(pnl_en_o == 0, "R1 enable", pnl_en_o, 0);
      chk(pnl_dq_oe_o == 0, "R1 oe", pnl_dq_oe_o, 0);
      chk(pnl_addr_o[1] == 1, "R1 rw", pnl_addr_o[1], 1);
      chk(dat_o == 0, "R1 dat_o", dat_o, 0);

      adr_i = 1'b1;
      @(negedge clk);
      chk(pnl_addr_o[0] == 1, "R2 follow high", pnl_addr_o[0], 1);
      adr_i = 1'b0;
      @(negedge clk);
      chk(pnl_addr_o[0] == 0, "R2 follow low", pnl_addr_o[0], 0);

      stb_i = 1'b1; cyc_i = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(pnl_en_o == 0 && ack_o == 0, "R9 strobe alone", {pnl_en_o, ack_o}, 0);
      end
      stb_i = 1'b0;

      xfer(1'b1, 1'b1, 8'hA5, 8'h00, 0);
      xfer(1'b0, 1'b0, 8'h00, 8'h3C, 0);
      xfer(1'b1, 1'b0, 8'h5A, 8'h00, 3);
      xfer(1'b0, 1'b1, 8'h00, 8'hC3, 4);
      last_rd = dat_o;
      xfer(1'b1, 1'b1, 8'hFF, 8'h00, 0);
      chk(dat_o == last_rd, "R8 write leaves dat_o", dat_o, last_rd);

      for (int t = 0; t < 24; t++) begin
         xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), int'($urandom % 4));
         repeat (int'($urandom % 3)) @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule